// File: doc/BRIEF.md
# Program Counter and Next-Address Unit

This block owns the program counter of a single-cycle processor. The counter register is the address that goes to instruction memory. Every instruction is fetched this way, and no other path forms a fetch address. In each cycle the block works out where the following instruction lives and loads that value on the next rising clock edge.

Three successors are possible. The first is the sequential address, which is the current counter plus four. The second is a PC-relative branch target. The branch is taken only when the decoder marks the instruction as a conditional branch and the register comparison reports equality. The third is a jump into the current 256 MB region. The jump keeps the top four bits of the sequential address and fills the rest from the 26-bit word target, followed by two zero bits.

The jump choice sits after the branch choice, so a jump wins over a taken branch. The register comparison and the instruction memory are outside this block. The block only takes in the decoded control bits and the offset and target fields.

Top module: `fetch_nextpc`

## Requirements
- R1: A synchronous active-high reset loads the counter with 0x00000000 on the rising edge, whatever the other inputs are.
- R2: `fetch_addr` always equals `pc_q`.
- R3: With `br_sel`=0 and `jump_en`=0, the counter advances to its current value plus 4.
- R4: With `br_sel`=1, `eq_flag`=1 and `jump_en`=0, the counter becomes current+4+(sign-extended `imm_off` shifted left by 2). Bit 15 of `imm_off` is its sign, so negative offsets move backwards.
- R5: A branch is not taken unless both `br_sel` and `eq_flag` are 1. With `br_sel`=1 and `eq_flag`=0, or with `br_sel`=0 and `eq_flag`=1, the counter becomes current+4.
- R6: With `jump_en`=1, the counter becomes {(current+4)[31:28], `jmp_field`[25:0], 2'b00}. The upper four bits come from current+4, so a jump placed in the last word of a region lands in the next region.
- R7: `jump_en`=1 overrides a taken branch, and the jump destination of R6 is loaded.
- R8: Bits [1:0] of the counter are always 0.
- R9: Address arithmetic wraps modulo 2^32. 0xFFFFFFFC followed by a sequential step gives 0x00000000, and a backward branch from 0x00000000 goes to the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| br_sel | input | 1 | Decoder marks a conditional branch |
| eq_flag | input | 1 | Register comparison reports equality |
| jump_en | input | 1 | Decoder marks a region-absolute jump |
| imm_off | input | 16 | Signed word offset of the branch |
| jmp_field | input | 26 | Word target of the jump |
| pc_q | output | 32 | Current program counter |
| fetch_addr | output | 32 | Instruction-memory address |

## Verification
The assertions assume that `br_sel`, `eq_flag` and `jump_en` hold 0 or 1 (never X) at every sampled edge once reset is released. They also assume that the offset and target fields are stable at the edge.

The bench meets these assumptions by changing every input only on the falling clock edge. All control bits are driven as defined values from reset onwards, and random phases draw whole fields. Wrap-around and region crossing are reached through directed branch and jump sequences. Arbitrary counter values cannot be forced from outside the block.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

  // Which successor the selector picked in a cycle.
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } nxpc_src_e;

  // Byte-to-word shift of all instruction addresses.
  localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/nxpc_seq_inc.sv
module nxpc_seq_inc #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_in,
  output logic [ADDR_W-1:0] pc_plus
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << nxpc_pkg::WORD_SHIFT;

  // Wraps naturally modulo 2^ADDR_W.
  always_comb pc_plus = pc_in + STEP;
endmodule

// File: rtl/nxpc_branch_calc.sv
module nxpc_branch_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [IMM_W-1:0]  offset,
  output logic [ADDR_W-1:0] br_addr
);
  localparam int unsigned SH  = nxpc_pkg::WORD_SHIFT;
  localparam int unsigned EXT = ADDR_W - IMM_W - SH;

  logic [ADDR_W-1:0] byte_off;

  // Sign-extend the word offset, then scale it to bytes.
  always_comb begin
    byte_off = {{EXT{offset[IMM_W-1]}}, offset, {SH{1'b0}}};
    br_addr  = seq_addr + byte_off;
  end
endmodule

// File: rtl/nxpc_jump_splice.sv
module nxpc_jump_splice #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TGT_W  = 26
) (
  input  logic [ADDR_W-TGT_W-nxpc_pkg::WORD_SHIFT-1:0] region,
  input  logic [TGT_W-1:0]                             target,
  output logic [ADDR_W-1:0]                            jmp_addr
);
  localparam int unsigned SH = nxpc_pkg::WORD_SHIFT;

  always_comb jmp_addr = {region, target, {SH{1'b0}}};
endmodule

// File: rtl/nxpc_select.sv
module nxpc_select #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              br_sel,
  input  logic              eq_flag,
  input  logic              jump_en,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] jmp_addr,
  output logic [ADDR_W-1:0] next_pc
);
  import nxpc_pkg::*;

  logic              take_br;
  logic [ADDR_W-1:0] stage1;
  nxpc_src_e         src;

  // First stage: branch versus sequential. Second stage: jump overrides.
  always_comb begin
    take_br = br_sel & eq_flag;
    stage1  = take_br ? br_addr : seq_addr;
    if (jump_en)      src = SRC_JUMP;
    else if (take_br) src = SRC_BRANCH;
    else              src = SRC_SEQ;
    next_pc = (src == SRC_JUMP) ? jmp_addr : stage1;
  end
endmodule

// File: rtl/fetch_nextpc.sv
module fetch_nextpc #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned TGT_W    = 26,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_sel,
  input  logic              eq_flag,
  input  logic              jump_en,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [TGT_W-1:0]  jmp_field,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int unsigned REGION_W = ADDR_W - TGT_W - nxpc_pkg::WORD_SHIFT;

  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] br_addr;
  logic [ADDR_W-1:0] jmp_addr;
  logic [ADDR_W-1:0] next_pc;

  nxpc_seq_inc #(.ADDR_W(ADDR_W)) u_inc (
    .pc_in   (pc_q),
    .pc_plus (seq_addr)
  );

  nxpc_branch_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_br (
    .seq_addr (seq_addr),
    .offset   (imm_off),
    .br_addr  (br_addr)
  );

  // Region bits are taken from the sequential address, not the raw counter.
  nxpc_jump_splice #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_jmp (
    .region   (seq_addr[ADDR_W-1 -: REGION_W]),
    .target   (jmp_field),
    .jmp_addr (jmp_addr)
  );

  nxpc_select #(.ADDR_W(ADDR_W)) u_sel (
    .br_sel   (br_sel),
    .eq_flag  (eq_flag),
    .jump_en  (jump_en),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .jmp_addr (jmp_addr),
    .next_pc  (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC[ADDR_W-1:0];
    else     pc_q <= next_pc;
  end

  assign fetch_addr = pc_q;
endmodule

// File: rtl/fetch_nextpc_chk.sv
module fetch_nextpc_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned TGT_W  = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              br_sel,
  input logic              eq_flag,
  input logic              jump_en,
  input logic [IMM_W-1:0]  imm_off,
  input logic [TGT_W-1:0]  jmp_field,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] fetch_addr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(4);
  localparam int unsigned RW = ADDR_W - TGT_W - 2;

  logic [ADDR_W-1:0] want_seq, want_br, want_jmp;
  always_comb begin
    want_seq = pc_q + STEP_V;
    want_br  = want_seq + ADDR_W'($signed(imm_off)) * STEP_V;
    want_jmp = {want_seq[ADDR_W-1 -: RW], jmp_field, 2'b00};
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> pc_q == '0);
  p_fetch_r2: assert property (@(posedge clk) disable iff (rst) fetch_addr == pc_q);
  p_seq_r3: assert property (@(posedge clk) disable iff (rst)
    (!br_sel && !jump_en) |=> pc_q == $past(want_seq));
  p_branch_r4: assert property (@(posedge clk) disable iff (rst)
    (br_sel && eq_flag && !jump_en) |=> pc_q == $past(want_br));
  p_untaken_r5: assert property (@(posedge clk) disable iff (rst)
    (br_sel && !eq_flag && !jump_en) |=> pc_q == $past(want_seq));
  p_jump_r6: assert property (@(posedge clk) disable iff (rst)
    jump_en |=> pc_q == $past(want_jmp));
  p_override_r7: assert property (@(posedge clk) disable iff (rst)
    (jump_en && br_sel && eq_flag) |=> pc_q == $past(want_jmp));
  p_align_r8: assert property (@(posedge clk) disable iff (rst) pc_q[1:0] == 2'b00);
  p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (pc_q == '1 - ADDR_W'(3) && !br_sel && !jump_en) |=> pc_q == '0);
endmodule

bind fetch_nextpc fetch_nextpc_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst(rst), .br_sel(br_sel), .eq_flag(eq_flag), .jump_en(jump_en),
  .imm_off(imm_off), .jmp_field(jmp_field), .pc_q(pc_q), .fetch_addr(fetch_addr)
);

// File: tb/sim_fetch_nextpc.sv
module sim_fetch_nextpc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_sel = 1'b0, eq_flag = 1'b0, jump_en = 1'b0;
  logic [15:0] imm_off = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] pc_q, fetch_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = '0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  fetch_nextpc u0 (
    .clk(clk), .rst(rst), .br_sel(br_sel), .eq_flag(eq_flag), .jump_en(jump_en),
    .imm_off(imm_off), .jmp_field(jmp_field), .pc_q(pc_q), .fetch_addr(fetch_addr)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Compare all outputs against the model (R2 fetch address, R8 alignment).
  task automatic compare(input string tag);
    check(tag, pc_q, model);
    check("R2 fetch_addr", fetch_addr, model);
    check("R8 alignment", {30'd0, pc_q[1:0]}, 32'd0);
  endtask

  // Called at a falling edge: drive, take one rising edge, compare at next falling edge.
  task automatic step(input logic b, input logic e, input logic j,
                      input logic [15:0] im, input logic [25:0] tg, input string tag);
    logic [31:0] p4, exp;
    p4  = model + 32'd4;
    exp = p4;
    if (b && e) exp = p4 + {{14{im[15]}}, im, 2'b00};
    if (j)      exp = {p4[31:28], tg, 2'b00};
    br_sel = b; eq_flag = e; jump_en = j; imm_off = im; jmp_field = tg;
    @(posedge clk);
    model = exp;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; jump_en = 1'b1; br_sel = 1'b1; eq_flag = 1'b1;
    imm_off = 16'h0040; jmp_field = 26'h123;
    @(posedge clk); @(negedge clk);
    model = 32'h0;
    compare(tag);
    rst = 1'b0; jump_en = 1'b0; br_sel = 1'b0; eq_flag = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    do_reset("R1 reset to zero");
    step(0, 0, 0, 16'h0,    26'h0,       "R3 sequential");
    step(0, 0, 0, 16'h7,    26'h0,       "R3 sequential ignores offset");
    step(1, 0, 0, 16'd100,  26'h0,       "R5 unequal branch not taken");
    step(0, 1, 0, 16'd100,  26'h0,       "R5 equality without branch");
    step(1, 1, 0, 16'd3,    26'h0,       "R4 forward branch");
    step(1, 1, 0, 16'hFFFC, 26'h0,       "R4 backward branch");
    step(0, 0, 1, 16'h0,    26'h3FFFFFF, "R6 jump to end of region");
    step(0, 0, 1, 16'h0,    26'h5,       "R6 region from PC+4");
    step(1, 1, 1, 16'd7,    26'h40,      "R7 jump overrides taken branch");
    step(1, 0, 1, 16'd7,    26'h80,      "R7 jump with untaken branch");
    do_reset("R1 mid-run reset");
    step(1, 1, 0, 16'hFFFE, 26'h0,       "R9 backward wrap below zero");
    step(0, 0, 0, 16'h0,    26'h0,       "R9 sequential wrap to zero");
    for (int i = 0; i < 3000; i++) begin
      logic b, e, j;
      b = ($urandom % 4) == 0;
      e = $urandom % 2;
      j = ($urandom % 8) == 0;
      step(b, e, j, 16'($urandom), 26'($urandom), "R3/R4/R5/R6 random mix");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule